// File: doc/BRIEF.md
# Parallel Host Mailbox and Audio FIFO Port

This block is the 8-bit parallel host port of an audio decoder. Its strobes follow the Intel style: an active-low chip select, separate active-low write and read enables, and a 2-bit register address. An interrupt request output tells the host that the core has a byte waiting for it. The strobes are asynchronous to the core clock. They are synchronized, and each access takes effect once, on the rising edge of its write or read enable while chip select is low.

The address selects one of four registers. The message register (00) is a one-byte mailbox in each direction, used for control bytes and code download. The control/status register (01) holds handshake flags, FIFO threshold flags and sticky overflow flags. The compressed-data register (10) and the PCM data register (11) are write-only. Each one feeds its own 16-entry FIFO, and the core drains that FIFO through a pop port. On the core side, the block offers a byte handshake for each direction of the mailbox.

Top module: `host_mailbox_port`

## Requirements
- R1: After reset, the control register reads 8'h01 (only bit 0, input-ready, set), the interrupt is low, both FIFOs are empty and no incoming byte is presented to the core.
- R2: A host write at address 00 presents the byte to the core (coreRxValid, coreRxData) and clears control bit 0 until the core takes it with coreRxTake. A second write while the byte is still pending is dropped.
- R3: A byte pushed by the core (coreTxValid while coreTxReady) sets control bit 1 and raises irq. A host read at address 00 returns that byte.
- R4: The rising read-enable edge of a host read at address 00 clears control bit 1 and drops irq.
- R5: Host writes at address 11 enter the PCM FIFO, and writes at address 10 enter the compressed FIFO. Each FIFO drains in write order through its pop port.
- R6: A host read at address 10 or 11 drives 8'h00 and removes nothing from either FIFO.
- R7: Control bit 2 is set while the PCM FIFO level is at or above the threshold input. Control bit 3 does the same for the compressed FIFO.
- R8: A write to a full FIFO is dropped and sets a sticky flag: bit 4 for the PCM FIFO, bit 5 for the compressed FIFO.
- R9: A host write at address 01 clears bit 4 and/or bit 5 wherever the written byte has a 1. No other flag changes.
- R10: An access acts exactly once, however long the enable is held low.
- R11: dataOe is high only while chip select and read enable are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low reset |
| csN | input | 1 | Host chip select, active low |
| wrN | input | 1 | Host write enable, active low |
| rdN | input | 1 | Host read enable, active low |
| addr | input | 2 | Register select |
| dataIn | input | 8 | Host write data |
| dataOut | output | 8 | Host read data |
| dataOe | output | 1 | Bus drive enable for dataOut |
| irq | output | 1 | Outgoing message pending |
| threshold | input | 5 | FIFO level threshold |
| coreRxValid | output | 1 | Incoming message byte pending |
| coreRxData | output | 8 | Incoming message byte |
| coreRxTake | input | 1 | Core consumes the incoming byte |
| coreTxValid | input | 1 | Core offers an outgoing byte |
| coreTxData | input | 8 | Outgoing byte |
| coreTxReady | output | 1 | Outgoing slot free |
| pcmPop | input | 1 | Pop PCM FIFO |
| pcmData | output | 8 | PCM FIFO head |
| pcmEmpty | output | 1 | PCM FIFO empty |
| cmpPop | input | 1 | Pop compressed FIFO |
| cmpData | output | 8 | Compressed FIFO head |
| cmpEmpty | output | 1 | Compressed FIFO empty |

## Verification
The bench holds a write enable low for many cycles. A design that acts on the level of the enable instead of its edge pushes the same byte several times, and the scoreboard finds extra entries. It writes 18 bytes into the compressed FIFO. A design that overwrites the head or wraps its pointers past full delivers the wrong order or loses early bytes, and one that does not latch the overflow reads back a clean flag after the drops. It also reads the write-only addresses while the FIFOs hold data, and writes the mailbox twice before the core consumes the first byte. Either mistake shows up as a popped entry, a nonzero read value, or a replaced pending byte.

// File: rtl/hpp_pkg.sv
package hpp_pkg;
  parameter int DATA_W = 8;

  typedef enum logic [1:0] {
    ADDR_MSG = 2'b00,
    ADDR_CTL = 2'b01,
    ADDR_CMP = 2'b10,
    ADDR_PCM = 2'b11
  } regAddr_t;

  localparam int CTL_IN_RDY  = 0;
  localparam int CTL_OUT_RDY = 1;
  localparam int CTL_PCM_THR = 2;
  localparam int CTL_CMP_THR = 3;
  localparam int CTL_PCM_OVF = 4;
  localparam int CTL_CMP_OVF = 5;

  typedef struct packed {
    logic wrMsg;
    logic wrCtl;
    logic wrPcm;
    logic wrCmp;
    logic rdMsg;
    logic [DATA_W-1:0] wdata;
  } hostStrobe_t;
endpackage

// File: rtl/hpp_fifo.sv
module hpp_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic push,
  input  logic [W-1:0] din,
  input  logic pop,
  output logic [W-1:0] dout,
  output logic full,
  output logic empty,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic pushOk, popOk;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign pushOk = push && !full;
  assign popOk  = pop && !empty;
  assign dout   = mem[rdPtr];
  assign level  = count;

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= wrPtr + 1'b1;
      if (popOk)  rdPtr <= rdPtr + 1'b1;
      count <= count + CW'(pushOk) - CW'(popOk);
    end
  end

  // R8: a push into a full FIFO with no pop leaves it full and unchanged
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> (full && $stable(wrPtr)));
  p_level_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
endmodule

// File: rtl/hpp_ctrl.sv
module hpp_ctrl
  import hpp_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic wrN,
  input  logic rdN,
  input  logic [1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output hostStrobe_t strobe
);
  logic [2:0] csSync, wrSync, rdSync;
  logic wrEdge, rdEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync <= '1;
      wrSync <= '1;
      rdSync <= '1;
    end else begin
      csSync <= {csSync[1:0], csN};
      wrSync <= {wrSync[1:0], wrN};
      rdSync <= {rdSync[1:0], rdN};
    end
  end

  assign wrEdge = wrSync[1] && !wrSync[2] && !csSync[2];
  assign rdEdge = rdSync[1] && !rdSync[2] && !csSync[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobe <= '0;
    end else begin
      strobe <= '0;
      strobe.wdata <= dataIn;
      if (wrEdge) begin
        unique case (regAddr_t'(addr))
          ADDR_MSG: strobe.wrMsg <= 1'b1;
          ADDR_CTL: strobe.wrCtl <= 1'b1;
          ADDR_CMP: strobe.wrCmp <= 1'b1;
          ADDR_PCM: strobe.wrPcm <= 1'b1;
        endcase
      end
      if (rdEdge && regAddr_t'(addr) == ADDR_MSG) strobe.rdMsg <= 1'b1;
    end
  end

  // R10: at most one access strobe at a time, each a single-cycle pulse
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrMsg, strobe.wrCtl, strobe.wrPcm, strobe.wrCmp, strobe.rdMsg}));
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrPcm || strobe.wrCmp) |=> !(strobe.wrPcm || strobe.wrCmp));
endmodule

// File: rtl/hpp_datapath.sv
module hpp_datapath
  import hpp_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CW = $clog2(FIFO_DEPTH+1)
) (
  input  logic clk,
  input  logic rstN,
  input  hostStrobe_t strobe,
  input  logic [1:0] addr,
  input  logic [CW-1:0] threshold,
  output logic [DATA_W-1:0] regView,
  output logic outPending,
  output logic coreRxValid,
  output logic [DATA_W-1:0] coreRxData,
  input  logic coreRxTake,
  input  logic coreTxValid,
  input  logic [DATA_W-1:0] coreTxData,
  output logic coreTxReady,
  input  logic pcmPop,
  output logic [DATA_W-1:0] pcmData,
  output logic pcmEmpty,
  input  logic cmpPop,
  output logic [DATA_W-1:0] cmpData,
  output logic cmpEmpty
);
  localparam int NCH = 2; // channel 0 = PCM, channel 1 = compressed

  logic [DATA_W-1:0] inMsg, outMsg;
  logic inFull, outFull;
  logic [NCH-1:0] fPush, fPop, fFull, fEmpty, fOvf, fThr;
  logic [DATA_W-1:0] fDout [NCH];
  logic [CW-1:0] fLevel [NCH];
  logic [DATA_W-1:0] ctlWord;

  assign fPush = {strobe.wrCmp, strobe.wrPcm};
  assign fPop  = {cmpPop, pcmPop};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    hpp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rstN(rstN), .push(fPush[ch]), .din(strobe.wdata),
      .pop(fPop[ch]), .dout(fDout[ch]), .full(fFull[ch]),
      .empty(fEmpty[ch]), .level(fLevel[ch]));

    assign fThr[ch] = (fLevel[ch] >= threshold);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) fOvf[ch] <= 1'b0;
      else if (fPush[ch] && fFull[ch]) fOvf[ch] <= 1'b1;
      else if (strobe.wrCtl && strobe.wdata[CTL_PCM_OVF + ch]) fOvf[ch] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inMsg <= '0;
      inFull <= 1'b0;
      outMsg <= '0;
      outFull <= 1'b0;
    end else begin
      if (strobe.wrMsg && !inFull) begin
        inMsg <= strobe.wdata;
        inFull <= 1'b1;
      end else if (coreRxTake) begin
        inFull <= 1'b0;
      end
      if (strobe.rdMsg) outFull <= 1'b0;
      else if (coreTxValid && !outFull) begin
        outMsg <= coreTxData;
        outFull <= 1'b1;
      end
    end
  end

  always_comb begin
    ctlWord = '0;
    ctlWord[CTL_IN_RDY]  = !inFull;
    ctlWord[CTL_OUT_RDY] = outFull;
    ctlWord[CTL_PCM_THR] = fThr[0];
    ctlWord[CTL_CMP_THR] = fThr[1];
    ctlWord[CTL_PCM_OVF] = fOvf[0];
    ctlWord[CTL_CMP_OVF] = fOvf[1];
  end

  always_comb begin
    unique case (regAddr_t'(addr))
      ADDR_MSG: regView = outMsg;
      ADDR_CTL: regView = ctlWord;
      default:  regView = '0;
    endcase
  end

  assign outPending  = outFull;
  assign coreTxReady = !outFull;
  assign coreRxValid = inFull;
  assign coreRxData  = inMsg;
  assign pcmData  = fDout[0];
  assign pcmEmpty = fEmpty[0];
  assign cmpData  = fDout[1];
  assign cmpEmpty = fEmpty[1];

  // R2: a write to a free mailbox captures the written byte
  p_in_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrMsg && !inFull) |=> (inFull && inMsg == $past(strobe.wdata)));
  // R2: a pending incoming byte is never replaced
  p_in_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inFull && !coreRxTake) |=> (inFull && $stable(inMsg)));
  // R4: a host read of the message register frees the outgoing slot
  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdMsg |=> !outFull);
  // R8: overflow flag stays set until explicitly cleared
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fOvf[1] && !(strobe.wrCtl && strobe.wdata[CTL_CMP_OVF])) |=> fOvf[1]);
endmodule

// File: rtl/host_mailbox_port.sv
module host_mailbox_port
  import hpp_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W = $clog2(FIFO_DEPTH+1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic wrN,
  input  logic rdN,
  input  logic [1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic dataOe,
  output logic irq,
  input  logic [LVL_W-1:0] threshold,
  output logic coreRxValid,
  output logic [DATA_W-1:0] coreRxData,
  input  logic coreRxTake,
  input  logic coreTxValid,
  input  logic [DATA_W-1:0] coreTxData,
  output logic coreTxReady,
  input  logic pcmPop,
  output logic [DATA_W-1:0] pcmData,
  output logic pcmEmpty,
  input  logic cmpPop,
  output logic [DATA_W-1:0] cmpData,
  output logic cmpEmpty
);
  hostStrobe_t strobe;
  logic [DATA_W-1:0] regView;
  logic outPending;

  hpp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN),
    .addr(addr), .dataIn(dataIn), .strobe(strobe));

  hpp_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .CW(LVL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr),
    .threshold(threshold), .regView(regView), .outPending(outPending),
    .coreRxValid(coreRxValid), .coreRxData(coreRxData), .coreRxTake(coreRxTake),
    .coreTxValid(coreTxValid), .coreTxData(coreTxData), .coreTxReady(coreTxReady),
    .pcmPop(pcmPop), .pcmData(pcmData), .pcmEmpty(pcmEmpty),
    .cmpPop(cmpPop), .cmpData(cmpData), .cmpEmpty(cmpEmpty));

  assign dataOe  = !csN && !rdN;
  assign dataOut = dataOe ? regView : '0;
  assign irq     = outPending;

  // R3: irq and the core's ready are always complementary
  p_irq_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    irq == !coreTxReady);
endmodule

// File: tb/host_mailbox_port_tb.sv
module host_mailbox_port_tb;
  logic clk = 0, rstN = 0;
  logic csN = 1, wrN = 1, rdN = 1;
  logic [1:0] addr = 0;
  logic [7:0] dataIn = 0, dataOut, coreRxData, coreTxData = 0, pcmData, cmpData;
  logic dataOe, irq, coreRxValid, coreRxTake = 0, coreTxValid = 0, coreTxReady;
  logic pcmPop = 0, pcmEmpty, cmpPop = 0, cmpEmpty;
  logic [4:0] threshold = 5'd3;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic [7:0] pcmQ[$], cmpQ[$];

  always #5 clk = ~clk;

  host_mailbox_port u_dut (.*);

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: performs the host write and records the expected FIFO entry
  task automatic hostWrite(logic [1:0] a, logic [7:0] d, int hold = 4);
    @(negedge clk);
    csN = 0; addr = a; dataIn = d;
    waitN(2); wrN = 0;
    waitN(hold); wrN = 1;
    waitN(6); csN = 1;
    waitN(2);
    if (a == 2'b11 && pcmQ.size() < 16) pcmQ.push_back(d);
    if (a == 2'b10 && cmpQ.size() < 16) cmpQ.push_back(d);
  endtask

  task automatic hostRead(logic [1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    csN = 0; addr = a;
    waitN(2); rdN = 0;
    waitN(4); d = dataOut; oe = dataOe;
    rdN = 1;
    waitN(6); csN = 1;
    waitN(2);
  endtask

  // Monitor: pops each FIFO and compares against the scoreboard
  task automatic drain(bit cmp, string req);
    forever begin
      @(negedge clk);
      if (cmp ? cmpEmpty : pcmEmpty) break;
      if ((cmp ? cmpQ.size() : pcmQ.size()) == 0) begin
        check(0, req, 1, 0);
        break;
      end
      begin
        logic [7:0] e, got;
        e = cmp ? cmpQ.pop_front() : pcmQ.pop_front();
        got = cmp ? cmpData : pcmData;
        check(got == e, req, got, e);
      end
      if (cmp) cmpPop = 1; else pcmPop = 1;
      @(negedge clk);
      cmpPop = 0; pcmPop = 0;
    end
    check((cmp ? cmpQ.size() : pcmQ.size()) == 0, req, cmp ? cmpQ.size() : pcmQ.size(), 0);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic oe;
    waitN(3); rstN = 1; waitN(2);

    // R1 reset state
    hostRead(2'b01, rd, oe);
    check(rd == 8'h01, "R1 ctl", rd, 8'h01);
    check(irq == 0 && !coreRxValid, "R1 irq/rx", {irq, coreRxValid}, 0);
    check(pcmEmpty && cmpEmpty, "R1 empty", {pcmEmpty, cmpEmpty}, 3);
    // R11 output enable
    csN = 0; waitN(1);
    check(dataOe == 0, "R11 oe idle", dataOe, 0);
    csN = 1; waitN(1);
    check(oe == 1, "R11 oe read", oe, 1);

    // R2 mailbox in
    hostWrite(2'b00, 8'hA5);
    check(coreRxValid && coreRxData == 8'hA5, "R2 rx", coreRxData, 8'hA5);
    hostRead(2'b01, rd, oe);
    check(rd[0] == 0, "R2 inrdy low", rd, 8'h00);
    hostWrite(2'b00, 8'h3C);
    check(coreRxData == 8'hA5, "R2 drop", coreRxData, 8'hA5);
    @(negedge clk) coreRxTake = 1;
    @(negedge clk) coreRxTake = 0;
    check(!coreRxValid, "R2 taken", coreRxValid, 0);
    hostRead(2'b01, rd, oe);
    check(rd == 8'h01, "R2 inrdy back", rd, 8'h01);

    // R3 / R4 mailbox out
    @(negedge clk) begin coreTxValid = 1; coreTxData = 8'h7E; end
    @(negedge clk) coreTxValid = 0;
    check(irq == 1, "R3 irq", irq, 1);
    hostRead(2'b01, rd, oe);
    check(rd == 8'h03, "R3 ctl", rd, 8'h03);
    hostRead(2'b00, rd, oe);
    check(rd == 8'h7E, "R3 data", rd, 8'h7E);
    check(irq == 0, "R4 irq clear", irq, 0);
    hostRead(2'b01, rd, oe);
    check(rd == 8'h01, "R4 ctl", rd, 8'h01);

    // R5 / R7 PCM feed and threshold
    hostWrite(2'b11, 8'h11);
    hostWrite(2'b11, 8'h22);
    hostRead(2'b01, rd, oe);
    check(rd[2] == 0, "R7 below", rd, 8'h01);
    hostWrite(2'b11, 8'h33);
    hostRead(2'b01, rd, oe);
    check(rd == 8'h05, "R7 reached", rd, 8'h05);
    hostWrite(2'b10, 8'h90);
    hostWrite(2'b10, 8'h91);

    // R6 write-only reads
    hostRead(2'b11, rd, oe);
    check(rd == 8'h00, "R6 pcm read", rd, 0);
    hostRead(2'b10, rd, oe);
    check(rd == 8'h00, "R6 cmp read", rd, 0);

    // R10 long strobe acts once
    hostWrite(2'b11, 8'h44, 20);
    drain(0, "R5 R6 R10 pcm order");

    // R8 overflow of compressed FIFO
    for (int i = 0; i < 16; i++) hostWrite(2'b10, 8'hA0 + 8'(i));
    hostRead(2'b01, rd, oe);
    check(rd == 8'h29, "R8 ovf flag", rd, 8'h29);

    // R9 clear sticky flag
    hostWrite(2'b01, 8'h20);
    hostRead(2'b01, rd, oe);
    check(rd == 8'h09, "R9 clear", rd, 8'h09);
    drain(1, "R5 R8 cmp order");

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule